// File: doc/BRIEF.md
# Multi-Input Wake-Up Detection Unit

The block watches a parameterised number of groups of eight asynchronous wake-up inputs and turns activity on them into latched pending flags and interrupt requests. Every input is first passed through a two-flop synchroniser. It is then gated by its own input-enable bit and examined by a per-input detector. The detector can be set for rising edges, falling edges, either edge, an active-high level or an active-low level. A detected event sets the input's pending bit, and that bit stays set until software clears it.

Within a group, each pending bit is masked by its interrupt-enable bit, and the group raises its interrupt when any masked bit is set. The group interrupts are then combined onto a smaller set of interrupt outputs. For each output, a group mask fixed at build time selects which groups are ORed onto it, so several groups can share one line.

Software reaches every register through a simple synchronous write and combinational read port. A service routine reads a group's pending register, writes ones to the clear register and dispatches on the bits it found.

Top module: `wkup_unit`

## Requirements
- R1: After reset, every mode, polarity, any-edge, input-enable, interrupt-enable and pending bit is 0, and `grp_irq` and `irq_out` are all low.
- R2: Address bits [2:0] select the register and the bits above them select the group. The selector codes are: 0 mode, 1 polarity, 2 any-edge, 3 input-enable, 4 interrupt-enable, 5 pending (read only), 6 pending-clear (write only, reads 0) and 7 (reads 0). Bit i of every register belongs to input group*8+i. The writable registers read back what was written.
- R3: A change on `wake_in` that the selected detector accepts is visible in the pending register after the third rising clock edge that follows the change, and not before it.
- R4: With mode 0 and any-edge 0, polarity 0 detects rising edges and polarity 1 detects falling edges. The opposite edge sets nothing.
- R5: With mode 0 and any-edge 1, both rising and falling edges set the pending bit.
- R6: With mode 1, polarity 0 detects a high level and polarity 1 detects a low level. The pending bit sets again on the cycle after a clear while the active level persists.
- R7: Writing a 1 to a pending-clear bit clears that pending bit. A 0 in the written value leaves its pending bit unchanged.
- R8: When a clear and a new event for the same bit fall in the same cycle, the pending bit remains 1.
- R9: `grp_irq[g]` is high exactly when group g has a bit set in both pending and interrupt-enable. Pending bits still latch while interrupt-enable is 0.
- R10: An input whose input-enable is 0 presents a constant 0 to its detector, so its toggles are ignored. Enabling an input that is held high in rising-edge mode produces a pending event.
- R11: `irq_out[k]` is the OR of `grp_irq[g]` over every group g whose bit is set in slice k of `IRQ_GROUP_MASKS` (bit k*NUM_GROUPS+g).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_in | input | NUM_GROUPS*8 | Asynchronous wake-up inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address {group, selector} |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| grp_irq | output | NUM_GROUPS | Per-group interrupt |
| irq_out | output | NUM_IRQ | Shared interrupt outputs after group masking |

## Verification
The bench builds the block with its defaults: four groups, two shared outputs and mask value 0x69. With that mask, output 0 combines groups 0 and 3 and output 1 combines groups 1 and 2. This is small enough to sweep all 32 inputs through all five detection settings, each with a rise, fall and clear sequence. It also lets the bench check, for every input, that the right group line and the right shared output respond. Directed cases pin down the three-edge latency, clear-versus-event collisions, masked clear writes and the event that appears when an input is enabled.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   localparam int GRP_BITS = 8;
   localparam int SEL_W    = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_MODE  = 3'd0,
      SEL_POL   = 3'd1,
      SEL_ANY   = 3'd2,
      SEL_INEN  = 3'd3,
      SEL_IRQEN = 3'd4,
      SEL_PEND  = 3'd5,
      SEL_CLR   = 3'd6,
      SEL_RSV   = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wkup_sync needs at least two stages");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wkup_sync width must be positive");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wkup_group.sv
module wkup_group
   import wkup_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  reg_sel_e            sel,
   input  logic [GRP_BITS-1:0] wdata,
   output logic [GRP_BITS-1:0] rdata,
   input  logic [GRP_BITS-1:0] in_sync,
   output logic                grp_irq
);
   logic [GRP_BITS-1:0] mode_q, pol_q, any_q, inen_q, irqen_q, pend_q;
   logic [GRP_BITS-1:0] prev_q;
   logic [GRP_BITS-1:0] gated, rise, fall, edge_evt, lvl_evt, evt, clr_mask;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         pol_q   <= '0;
         any_q   <= '0;
         inen_q  <= '0;
         irqen_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_MODE:  mode_q  <= wdata;
            SEL_POL:   pol_q   <= wdata;
            SEL_ANY:   any_q   <= wdata;
            SEL_INEN:  inen_q  <= wdata;
            SEL_IRQEN: irqen_q <= wdata;
            default: ;
         endcase
      end
   end

   // detection
   assign gated    = in_sync & inen_q;
   assign rise     = gated & ~prev_q;
   assign fall     = ~gated & prev_q;
   assign edge_evt = (any_q & (rise | fall))
                   | (~any_q & pol_q & fall)
                   | (~any_q & ~pol_q & rise);
   assign lvl_evt  = gated ^ pol_q;
   assign evt      = (mode_q & lvl_evt) | (~mode_q & edge_evt);
   assign clr_mask = (wr_en && sel == SEL_CLR) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= gated;
         pend_q <= (pend_q & ~clr_mask) | evt;
      end
   end

   assign grp_irq = |(pend_q & irqen_q);

   always_comb begin
      case (sel)
         SEL_MODE:  rdata = mode_q;
         SEL_POL:   rdata = pol_q;
         SEL_ANY:   rdata = any_q;
         SEL_INEN:  rdata = inen_q;
         SEL_IRQEN: rdata = irqen_q;
         SEL_PEND:  rdata = pend_q;
         default:   rdata = '0;
      endcase
   end

   // R7
   clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_mask & ~evt) != '0) |=> ((pend_q & $past(clr_mask & ~evt)) == '0));

   // R8
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

   // R4
   pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0));

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irqen_q == '0) |-> !grp_irq);
endmodule

// File: rtl/wkup_irq_merge.sv
module wkup_irq_merge #(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_IRQ    = 2,
   parameter logic [NUM_IRQ*NUM_GROUPS-1:0] MASKS = '1
) (
   input  logic [NUM_GROUPS-1:0] grp_irq,
   output logic [NUM_IRQ-1:0]    irq_out
);
   for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
      localparam logic [NUM_GROUPS-1:0] SLICE = MASKS[k*NUM_GROUPS +: NUM_GROUPS];
      if (SLICE == '0) begin : g_unused
         assign irq_out[k] = 1'b0;
      end else begin : g_used
         assign irq_out[k] = |(grp_irq & SLICE);
      end
   end
endmodule

// File: rtl/wkup_unit.sv
module wkup_unit
   import wkup_pkg::*;
#(
   parameter int NUM_GROUPS  = 4,
   parameter int NUM_IRQ     = 2,
   parameter int SYNC_STAGES = 2,
   parameter logic [NUM_IRQ*NUM_GROUPS-1:0] IRQ_GROUP_MASKS = 8'h69,
   localparam int GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int ADDR_W = GIDX_W + SEL_W,
   localparam int NUM_IN = NUM_GROUPS * GRP_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_IN-1:0]     wake_in,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [GRP_BITS-1:0]   bus_wdata,
   output logic [GRP_BITS-1:0]   bus_rdata,
   output logic [NUM_GROUPS-1:0] grp_irq,
   output logic [NUM_IRQ-1:0]    irq_out
);
   if (NUM_GROUPS < 1) begin : g_bad_groups
      $error("wkup_unit needs at least one group");
   end
   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("wkup_unit needs at least one interrupt output");
   end

   logic [NUM_IN-1:0]   sync_w;
   logic [GIDX_W-1:0]   gidx;
   reg_sel_e            reg_sel;
   logic [GRP_BITS-1:0] grp_rdata [NUM_GROUPS];

   assign gidx    = bus_addr[ADDR_W-1:SEL_W];
   assign reg_sel = reg_sel_e'(bus_addr[SEL_W-1:0]);

   wkup_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wake_in),
      .q     (sync_w)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic hit;
      assign hit = (gidx == GIDX_W'(g));
      wkup_group u_grp (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_wr && hit),
         .sel     (reg_sel),
         .wdata   (bus_wdata),
         .rdata   (grp_rdata[g]),
         .in_sync (sync_w[g*GRP_BITS +: GRP_BITS]),
         .grp_irq (grp_irq[g])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (gidx == GIDX_W'(g)) bus_rdata = grp_rdata[g];
      end
   end

   wkup_irq_merge #(
      .NUM_GROUPS (NUM_GROUPS),
      .NUM_IRQ    (NUM_IRQ),
      .MASKS      (IRQ_GROUP_MASKS)
   ) u_merge (
      .grp_irq (grp_irq),
      .irq_out (irq_out)
   );

   // R11
   merge_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_irq == '0) |-> (irq_out == '0));
endmodule

// File: tb/wkup_unit_tb_top.sv
module wkup_unit_tb_top;
   localparam int NG = 4;
   localparam int NI = 2;
   localparam logic [7:0] MASKS = 8'h69;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NG*8-1:0] wake_in = '0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic [NG-1:0] grp_irq;
   logic [NI-1:0] irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wkup_unit #(.NUM_GROUPS(NG), .NUM_IRQ(NI), .IRQ_GROUP_MASKS(MASKS)) dut_i (
      .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .grp_irq(grp_irq), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int g, input int sel, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = AW'(g * 8 + sel);
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int g, input int sel, output logic [7:0] v);
      bus_addr = AW'(g * 8 + sel);
      #1;
      v = bus_rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [NI-1:0] exp_irq(input logic [NG-1:0] grp);
      logic [NI-1:0] r;
      for (int k = 0; k < NI; k++) r[k] = |(grp & MASKS[k*NG +: NG]);
      return r;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R1 reset state, R2 all selectors read 0
      for (int g = 0; g < NG; g++)
         for (int s = 0; s < 8; s++) begin
            rd(g, s, v);
            chk("R1 reset register", {24'd0, v}, 32'd0);
         end
      chk("R1 reset grp_irq", {28'd0, grp_irq}, 32'd0);
      chk("R1 reset irq_out", {30'd0, irq_out}, 32'd0);

      // R2 readback of writable registers
      for (int g = 0; g < NG; g++)
         for (int s = 0; s < 5; s++) wr(g, s, 8'((g * 16 + s * 3 + 1)));
      for (int g = 0; g < NG; g++)
         for (int s = 0; s < 5; s++) begin
            rd(g, s, v);
            chk("R2 readback", {24'd0, v}, 32'(8'((g * 16 + s * 3 + 1))));
         end
      for (int g = 0; g < NG; g++) begin
         for (int s = 0; s < 5; s++) wr(g, s, 8'h00);
         wr(g, 6, 8'hFF);
      end
      wait_n(4);
      for (int g = 0; g < NG; g++) wr(g, 6, 8'hFF);

      // R3 latency: group 0 bit 0, rising edge mode
      wr(0, 3, 8'h01);
      wait_n(4);
      wr(0, 6, 8'hFF);
      wake_in[0] = 1'b1;
      wait_n(2);
      rd(0, 5, v);
      chk("R3 not yet after two edges", {24'd0, v}, 32'd0);
      wait_n(1);
      rd(0, 5, v);
      chk("R3 set after third edge", {24'd0, v}, 32'h01);
      rd(0, 6, v);
      chk("R2 clear register reads 0", {24'd0, v}, 32'd0);

      // R7 zero bits in clear have no effect
      wr(0, 6, 8'h00);
      rd(0, 5, v);
      chk("R7 clear with 0", {24'd0, v}, 32'h01);
      wr(0, 6, 8'h02);
      rd(0, 5, v);
      chk("R7 clear other bit", {24'd0, v}, 32'h01);
      wr(0, 6, 8'h01);
      rd(0, 5, v);
      chk("R7 clear own bit", {24'd0, v}, 32'd0);

      // R9 pending latches with interrupt disabled
      wake_in[0] = 1'b0;
      wait_n(4);
      wake_in[0] = 1'b1;
      wait_n(4);
      rd(0, 5, v);
      chk("R9 latched while masked", {24'd0, v}, 32'h01);
      chk("R9 masked grp_irq", {28'd0, grp_irq}, 32'd0);
      wr(0, 4, 8'h01);
      chk("R9 unmasked grp_irq", {28'd0, grp_irq}, 32'h1);
      chk("R11 shared line", {30'd0, irq_out}, 32'(exp_irq(4'h1)));
      wr(0, 4, 8'h00);
      wake_in[0] = 1'b0;
      wr(0, 3, 8'h00);
      wait_n(4);
      wr(0, 6, 8'hFF);

      // R8 event wins over clear: group 1 bit 3, level high held
      wr(1, 0, 8'h08);
      wr(1, 3, 8'h08);
      wake_in[11] = 1'b1;
      wait_n(4);
      wr(1, 6, 8'hFF);
      rd(1, 5, v);
      chk("R8 event beats clear", {24'd0, v}, 32'h08);
      wr(1, 3, 8'h00);
      wr(1, 0, 8'h00);
      wake_in[11] = 1'b0;
      wait_n(4);
      wr(1, 6, 8'hFF);

      // R10 disabled input ignored, then enabling raises event
      wake_in[21] = 1'b1;
      wait_n(4);
      wake_in[21] = 1'b0;
      wait_n(4);
      wake_in[21] = 1'b1;
      wait_n(4);
      rd(2, 5, v);
      chk("R10 disabled input ignored", {24'd0, v}, 32'd0);
      wr(2, 3, 8'h20);
      wait_n(2);
      rd(2, 5, v);
      chk("R10 enable raises event", {24'd0, v}, 32'h20);
      wr(2, 3, 8'h00);
      wake_in[21] = 1'b0;
      wait_n(4);
      wr(2, 6, 8'hFF);

      // sweep: every input through rise, fall, any, high, low
      for (int m = 0; m < 5; m++) begin
         for (int i = 0; i < NG * 8; i++) begin
            int g;
            int b;
            logic [7:0] bm;
            logic e1, e2, e3, e4;
            logic [NG-1:0] eg;
            g = i / 8;
            b = i % 8;
            bm = 8'(1 << b);
            e1 = (m == 4);
            e2 = (m != 1);
            e3 = (m == 3);
            e4 = (m != 0);
            wr(g, 0, (m >= 3) ? bm : 8'h00);
            wr(g, 1, (m == 1 || m == 4) ? bm : 8'h00);
            wr(g, 2, (m == 2) ? bm : 8'h00);
            wr(g, 3, bm);
            wr(g, 4, bm);
            wait_n(4);
            wr(g, 6, 8'hFF);
            wait_n(4);
            rd(g, 5, v);
            chk(m >= 3 ? "R6 low idle" : "R4 idle", {24'd0, v}, e1 ? 32'(bm) : 32'd0);
            wake_in[i] = 1'b1;
            wait_n(4);
            rd(g, 5, v);
            chk(m == 2 ? "R5 rise" : (m >= 3 ? "R6 after rise" : "R4 rise"),
                {24'd0, v}, e2 ? 32'(bm) : 32'd0);
            wr(g, 6, 8'hFF);
            wait_n(4);
            rd(g, 5, v);
            chk(m >= 3 ? "R6 re-set after clear" : "R7 cleared", {24'd0, v}, e3 ? 32'(bm) : 32'd0);
            wake_in[i] = 1'b0;
            wait_n(4);
            rd(g, 5, v);
            chk(m == 2 ? "R5 fall" : (m >= 3 ? "R6 after fall" : "R4 fall"),
                {24'd0, v}, e4 ? 32'(bm) : 32'd0);
            eg = e4 ? NG'(1 << g) : '0;
            chk("R9 group line", {28'd0, grp_irq}, 32'(eg));
            chk("R11 shared lines", {30'd0, irq_out}, 32'(exp_irq(eg)));
            wr(g, 4, 8'h00);
            wr(g, 3, 8'h00);
            wr(g, 0, 8'h00);
            wr(g, 1, 8'h00);
            wr(g, 2, 8'h00);
            wait_n(2);
            wr(g, 6, 8'hFF);
         end
      end

      finish_run();
   end
endmodule